// File: doc/BRIEF.md
# Validation Counter Run Control

This block sits on the write path of the system control coprocessor. It turns the start and stop operations aimed at the validation counters into four run flags: reset, interrupt, fast interrupt and external debug request. A write picks a command with its first opcode field. For the three maskable counters, the second opcode field is a bitmask, so one write can start or stop any mix of them. The external debug request counter has its own pair of commands, and those commands ignore the mask.

The block checks every access against the current security world, the privilege level, a validation-enable bit and a lockout input that forbids secure writes. A refused access produces a one-cycle undefined-exception pulse in the same cycle as the strobe, and the run flags stay as they were. A read never changes state and always returns zero. The count values and what happens when a counter expires belong to the counters themselves, not to this block.

Top module: `vcnt_run_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four run flags, and `undef_o` is low while reset is held.
- R2: An accepted write with command 0 sets the run flags chosen by the mask in `op_sel_i`. Mask bit 0 selects the reset flag (`run_o[0]`), bit 1 the interrupt flag (`run_o[1]`) and bit 2 the fast-interrupt flag (`run_o[2]`). Flags not chosen keep their value, and the change appears after the clock edge that samples the strobe.
- R3: An accepted write with command 2 clears only the run flags chosen by the same mask and leaves the others unchanged.
- R4: Command 1 sets the debug flag (`run_o[3]`) and command 3 clears it, whatever the mask value. Neither command touches `run_o[2:0]`.
- R5: An access is addressed only when `reg_pri_i` is 15 and `reg_sec_i` is 13. Any other register pair causes no flag change and no exception.
- R6: A write from secure privileged state is accepted whatever `val_en_i` is, unless `sec_lock_i` is high. With the lock high, the write pulses `undef_o` and changes no flag.
- R7: With `val_en_i` low, any read or write made outside secure privileged state pulses `undef_o` and changes no flag. This covers non-secure privileged state and user mode in either world.
- R8: With `val_en_i` high, writes made outside secure privileged state are accepted, and `sec_lock_i` has no effect on them.
- R9: A read never changes a run flag, and `rdata_o` is always zero.
- R10: An otherwise permitted write with command 4, 5, 6 or 7 pulses `undef_o` and changes no flag.
- R11: Command 0 or 2 with a mask of 0 is accepted with no exception and changes no flag.
- R12: `undef_o` is high only in a cycle where a strobe is present, so a refused access gives a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Coprocessor write strobe |
| rd_en_i | input | 1 | Coprocessor read strobe |
| op_cmd_i | input | 3 | First opcode field (command) |
| op_sel_i | input | 3 | Second opcode field (counter mask) |
| reg_pri_i | input | 4 | Primary register number |
| reg_sec_i | input | 4 | Secondary register number |
| secure_i | input | 1 | 1 = secure world |
| priv_i | input | 1 | 1 = privileged, 0 = user |
| val_en_i | input | 1 | Validation-enable bit |
| sec_lock_i | input | 1 | Secure write lockout |
| run_o | output | 4 | Run flags: [0] reset, [1] interrupt, [2] fast interrupt, [3] debug request |
| undef_o | output | 1 | Undefined-exception pulse, same cycle as the strobe |
| rdata_o | output | 32 | Read data, always zero |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that the mode and opcode inputs are stable and valid whenever a strobe is high. The stimulus respects both assumptions: it changes every input only on the falling edge, holds at most one strobe high in any cycle, and drops both strobes between operations. This leaves a quiet cycle in which the bench can see that the exception pulse has ended.

// File: rtl/vcnt_pkg.sv
`timescale 1ns/1ps
package vcnt_pkg;

    localparam int OP_W     = 3;
    localparam int REG_W    = 4;
    localparam int MASK_W   = OP_W;
    localparam int FLAG_W   = MASK_W + 1;
    localparam int FLAG_DBG = MASK_W;

    typedef enum logic [OP_W-1:0] {
        CMD_START_SEL = 3'd0,
        CMD_START_DBG = 3'd1,
        CMD_STOP_SEL  = 3'd2,
        CMD_STOP_DBG  = 3'd3
    } cmd_e;

    typedef struct packed {
        logic [FLAG_W-1:0] set_mask;
        logic [FLAG_W-1:0] clr_mask;
        logic              legal;
    } cmd_dec_t;

    typedef struct packed {
        logic accept_wr;
        logic refuse;
    } access_t;

endpackage

// File: rtl/vcnt_cmd_dec.sv
`timescale 1ns/1ps
module vcnt_cmd_dec
    import vcnt_pkg::*;
#(
    parameter int P_OP_W   = OP_W,
    parameter int P_MASK_W = MASK_W
) (
    input  logic [P_OP_W-1:0] cmd_i,
    input  logic [P_OP_W-1:0] sel_i,
    output cmd_dec_t          dec_o
);

    localparam int LP_FLAGS = P_MASK_W + 1;

    logic start_sel, stop_sel, start_dbg, stop_dbg;
    logic [LP_FLAGS-1:0] set_v, clr_v;

    always_comb begin
        start_sel = (cmd_i == CMD_START_SEL);
        stop_sel  = (cmd_i == CMD_STOP_SEL);
        start_dbg = (cmd_i == CMD_START_DBG);
        stop_dbg  = (cmd_i == CMD_STOP_DBG);
    end

    for (genvar g = 0; g < P_MASK_W; g++) begin : g_sel
        assign set_v[g] = start_sel & sel_i[g];
        assign clr_v[g] = stop_sel  & sel_i[g];
    end

    assign set_v[P_MASK_W] = start_dbg;
    assign clr_v[P_MASK_W] = stop_dbg;

    always_comb begin
        dec_o.set_mask = set_v;
        dec_o.clr_mask = clr_v;
        dec_o.legal    = start_sel | stop_sel | start_dbg | stop_dbg;
    end

endmodule

// File: rtl/vcnt_access_chk.sv
`timescale 1ns/1ps
module vcnt_access_chk
    import vcnt_pkg::*;
(
    input  logic    wr_i,
    input  logic    rd_i,
    input  logic    hit_i,
    input  logic    secure_i,
    input  logic    priv_i,
    input  logic    val_en_i,
    input  logic    lock_i,
    input  logic    cmd_legal_i,
    output access_t acc_o
);

    logic sec_priv;
    logic wr_denied;
    logic rd_denied;

    always_comb begin
        sec_priv  = secure_i & priv_i;
        // Secure privileged writes answer only to the lockout; every other
        // state answers only to the validation-enable bit.
        wr_denied = sec_priv ? lock_i : ~val_en_i;
        rd_denied = ~sec_priv & ~val_en_i;

        acc_o.accept_wr = 1'b0;
        acc_o.refuse    = 1'b0;
        if (hit_i) begin
            if (wr_i) begin
                acc_o.accept_wr = ~wr_denied & cmd_legal_i;
                acc_o.refuse    = wr_denied | ~cmd_legal_i;
            end else if (rd_i) begin
                acc_o.refuse    = rd_denied;
            end
        end
    end

endmodule

// File: rtl/vcnt_run_ctrl.sv
`timescale 1ns/1ps
module vcnt_run_ctrl
    import vcnt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PRI_SEL = 15,
    parameter int SEC_SEL = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [OP_W-1:0]   op_cmd_i,
    input  logic [OP_W-1:0]   op_sel_i,
    input  logic [REG_W-1:0]  reg_pri_i,
    input  logic [REG_W-1:0]  reg_sec_i,
    input  logic              secure_i,
    input  logic              priv_i,
    input  logic              val_en_i,
    input  logic              sec_lock_i,
    output logic [FLAG_W-1:0] run_o,
    output logic              undef_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [FLAG_W-1:0] run;
    } state_t;

    state_t   st_d, st_q;
    cmd_dec_t dec;
    access_t  acc;
    logic     hit;

    assign hit = (reg_pri_i == REG_W'(PRI_SEL)) && (reg_sec_i == REG_W'(SEC_SEL));

    vcnt_cmd_dec #(
        .P_OP_W   (OP_W),
        .P_MASK_W (MASK_W)
    ) u_dec (
        .cmd_i (op_cmd_i),
        .sel_i (op_sel_i),
        .dec_o (dec)
    );

    vcnt_access_chk u_acc (
        .wr_i        (wr_en_i),
        .rd_i        (rd_en_i),
        .hit_i       (hit),
        .secure_i    (secure_i),
        .priv_i      (priv_i),
        .val_en_i    (val_en_i),
        .lock_i      (sec_lock_i),
        .cmd_legal_i (dec.legal),
        .acc_o       (acc)
    );

    always_comb begin
        st_d = st_q;
        if (acc.accept_wr) begin
            st_d.run = (st_q.run | dec.set_mask) & ~dec.clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign undef_o = acc.refuse & ~rst;
    assign rdata_o = '0;

    // R12: an exception pulse needs a strobe in the same cycle
    a_r12_pulse_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (wr_en_i || rd_en_i));

    // R9: a lone read leaves the flags alone
    a_r9_read_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i) |=> $stable(run_o));

    // R9: read data is always zero
    a_r9_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        rdata_o == '0);

    // R6: a locked secure privileged write is refused
    a_r6_lock_refuses: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit && secure_i && priv_i && sec_lock_i) |-> undef_o);

    // R6: a refused write leaves the flags alone
    a_r6_refused_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && undef_o) |=> $stable(run_o));

    // R7: gated states without the enable bit are refused
    a_r7_gated_refused: assert property (@(posedge clk) disable iff (rst)
        ((wr_en_i || rd_en_i) && hit && !(secure_i && priv_i) && !val_en_i) |-> undef_o);

    // R5: unaddressed writes change nothing and raise nothing
    a_r5_unaddressed_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !hit) |-> (!undef_o ##1 $stable(run_o)));

    // R10: commands above 3 are refused
    a_r10_bad_cmd_refused: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit && op_cmd_i[2]) |-> undef_o);

    // R1: flags are zero the cycle after reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (run_o == '0));

endmodule

// File: tb/vcnt_run_ctrl_tb.sv
`timescale 1ns/1ps
module vcnt_run_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [2:0]  op_cmd, op_sel;
    logic [3:0]  reg_pri, reg_sec;
    logic        secure, priv, val_en, sec_lock;
    logic [3:0]  run;
    logic        undef;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    vcnt_run_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .op_cmd_i   (op_cmd),
        .op_sel_i   (op_sel),
        .reg_pri_i  (reg_pri),
        .reg_sec_i  (reg_sec),
        .secure_i   (secure),
        .priv_i     (priv),
        .val_en_i   (val_en),
        .sec_lock_i (sec_lock),
        .run_o      (run),
        .undef_o    (undef),
        .rdata_o    (rdata)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [2:0] cmd;
        logic [2:0] sel;
        logic       sec;
        logic       prv;
        logic       ven;
        logic       lock;
        logic       hit;
        logic       x_undef;
        logic [3:0] x_run;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    // fields: wr rd cmd sel sec prv ven lock hit x_undef x_run req
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,3'd0,3'b001,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0001,4'd2},  // R2
        '{1'b1,1'b0,3'd0,3'b110,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0111,4'd2},  // R2
        '{1'b1,1'b0,3'd1,3'b101,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b1111,4'd4},  // R4
        '{1'b1,1'b0,3'd2,3'b010,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b1101,4'd3},  // R3
        '{1'b1,1'b0,3'd3,3'b000,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0101,4'd4},  // R4
        '{1'b1,1'b0,3'd2,3'b000,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0101,4'd11}, // R11
        '{1'b1,1'b0,3'd0,3'b000,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0101,4'd11}, // R11
        '{1'b1,1'b0,3'd0,3'b111,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,4'b0101,4'd6},  // R6
        '{1'b1,1'b0,3'd0,3'b010,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,4'b0101,4'd7},  // R7
        '{1'b1,1'b0,3'd2,3'b001,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,4'b0101,4'd7},  // R7
        '{1'b0,1'b1,3'd0,3'b000,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'b0101,4'd7},  // R7
        '{1'b1,1'b0,3'd0,3'b010,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'b0111,4'd8},  // R8
        '{1'b1,1'b0,3'd1,3'b111,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'b1111,4'd8},  // R8
        '{1'b1,1'b0,3'd2,3'b100,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'b1011,4'd8},  // R8
        '{1'b1,1'b0,3'd5,3'b111,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'b1011,4'd10}, // R10
        '{1'b1,1'b0,3'd7,3'b001,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'b1011,4'd10}, // R10
        '{1'b1,1'b0,3'd2,3'b111,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'b1011,4'd5},  // R5
        '{1'b0,1'b1,3'd2,3'b111,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b1011,4'd9},  // R9
        '{1'b0,1'b1,3'd0,3'b111,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'b1011,4'd9},  // R9
        '{1'b0,1'b0,3'd5,3'b111,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,4'b1011,4'd12}, // R12
        '{1'b1,1'b0,3'd3,3'b000,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,4'b1011,4'd6},  // R6
        '{1'b1,1'b0,3'd3,3'b000,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'b0011,4'd6}   // R6
    };

    function automatic void check(input string req, input string what,
                                  input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endfunction

    function automatic void summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endfunction

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0;
        op_cmd = 3'd0; op_sel = 3'd0;
        reg_pri = 4'd15; reg_sec = 4'd13;
        secure = 1'b1; priv = 1'b1; val_en = 1'b0; sec_lock = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_en = v.wr; rd_en = v.rd;
        op_cmd = v.cmd; op_sel = v.sel;
        reg_pri = 4'd15;
        reg_sec = v.hit ? 4'd13 : 4'd12;
        secure = v.sec; priv = v.prv; val_en = v.ven; sec_lock = v.lock;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 5000) begin
            n_bad++;
            $display("FAIL watchdog R12 run: actual=%0d cycles expected<5000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "run after reset", 32'(run), 32'h0);
        check("R1", "undef in reset", 32'(undef), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d[v%0d]", VEC[i].req, i);
            apply(VEC[i]);
            #1;
            check(tag, "undef", 32'(undef), 32'(VEC[i].x_undef));
            check(tag, "rdata", rdata, 32'h0);
            @(negedge clk);
            idle();
            check(tag, "run", 32'(run), 32'(VEC[i].x_run));
        end

        // R12: the pulse lasts one cycle only
        apply('{1'b1,1'b0,3'd6,3'b000,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,4'b0011,4'd12});
        #1;
        check("R12", "undef with strobe", 32'(undef), 32'h1);
        @(negedge clk);
        idle();
        #1;
        check("R12", "undef after strobe", 32'(undef), 32'h0);
        check("R10", "run after bad cmd", 32'(run), 32'h3);

        // R4: debug start with every mask leaves masked flags alone
        for (int m = 0; m < 8; m++) begin
            apply('{1'b1,1'b0,3'd1,3'(m),1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'b0,4'd4});
            @(negedge clk);
            idle();
            check("R4", "run after debug start", 32'(run), 32'hB);
        end

        // R1: reset in the middle of operation clears every flag
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "run after mid reset", 32'(run), 32'h0);

        // R2 with R8: user-mode start of all three masked counters
        apply('{1'b1,1'b0,3'd0,3'b111,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'b0,4'd8});
        @(negedge clk);
        idle();
        check("R2", "run after full start", 32'(run), 32'h7);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule